// File: doc/BRIEF.md
# Key-Serviced Watchdog Timer

This block is a watchdog that, once armed by software, counts down a programmed number of half-second periods. A half-second tick input paces the count. Software keeps the system alive by writing a two-word key pair to a service register. If the count runs out before the next valid key pair, the block drives a reset pulse of fixed length. After that it stays expired until the system reset is applied.

There are two 16-bit write registers, selected by a one-bit address. Address 0 is control: the timeout field sits in bits 15:8 and the enable bit is bit 2. Address 1 is service. A timeout field value of k gives k+1 ticks, so the range runs from 0.5 s (k=0x00) to 128 s (k=0xFF). The field comes out of reset at 0x7F, which is 64 s. Writes are single-cycle strobes with no handshake, because the register port is a control interface and carries no data stream. The control register reads back on a dedicated output.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, `reg_rdata` reads 0x7F00 and `wdt_rst` is low.
- R2: A write to address 0 stores bits 15:8 as the timeout field and bit 2 as enable. `reg_rdata` returns the field in bits 15:8, enable in bit 2, and zero in every other bit.
- R3: Once enable is 1, a control write with bit 2 clear leaves enable at 1 until system reset. The timeout field is still updated by that write.
- R4: Enabling with field value k loads the count. Without service, `wdt_rst` rises after the (k+1)-th `half_tick` pulse, in the cycle after the tick is sampled.
- R5: Writing 0x5555 and then 0xAAAA to address 1 reloads the count from the current field. The next expiry then needs a full k+1 ticks again.
- R6: A service write of any value other than 0xAAAA or 0x5555 after 0x5555 cancels the sequence. A 0xAAAA that does not directly follow a 0x5555 reloads nothing.
- R7: A repeated 0x5555 keeps the sequence armed, so a following 0xAAAA still reloads.
- R8: On expiry `wdt_rst` is high for exactly 4 consecutive cycles. After that it stays low, and later ticks and service writes have no effect until system reset.
- R9: While enable is 0, ticks do not count and `wdt_rst` stays low.
- R10: Enabling with the reset-value field 0x7F expires on the 128th tick.
- R11: A reload in the same cycle as a tick takes precedence. That tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| half_tick | input | 1 | One-cycle pulse every half second |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = service |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Control register readback |
| wdt_rst | output | 1 | Reset pulse on expiry |

## Verification
The hardest case to reach is a key completion landing in the same cycle as a tick. It only matters when the count is near zero, so it decides between a reload and an expiry. The bench drives the 0xAAAA write and the tick in one cycle with one tick of budget left. It then confirms that one more tick is survived and the following tick expires. The post-expiry quiet phase is also reached on purpose: ticks and a full key pair are sent after the pulse, and `wdt_rst` must stay low.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int REG_W     = 16;
  localparam int TO_W      = 8;
  localparam int TO_LSB    = 8;
  localparam int EN_BIT    = 2;
  localparam logic [REG_W-1:0] KEY_FIRST  = 16'h5555;
  localparam logic [REG_W-1:0] KEY_SECOND = 16'hAAAA;
  localparam logic [TO_W-1:0]  TO_RESET   = 8'h7F;
  typedef enum logic {ADDR_CTRL = 1'b0, ADDR_SVC = 1'b1} reg_addr_e;
endpackage

// File: rtl/wdk_ctrl_reg.sv
module wdk_ctrl_reg
  import wdk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic [REG_W-1:0] wdata,
  output logic [TO_W-1:0]  field_q,
  output logic             en_q,
  output logic             start,
  output logic [TO_W-1:0]  start_val,
  output logic [REG_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field_q <= TO_RESET;
      en_q    <= 1'b0;
    end else if (wr_ctrl) begin
      field_q <= wdata[TO_LSB +: TO_W];
      if (wdata[EN_BIT]) en_q <= 1'b1;
    end
  end

  assign start     = wr_ctrl && wdata[EN_BIT] && !en_q;
  assign start_val = wdata[TO_LSB +: TO_W];

  always_comb begin
    rdata = '0;
    rdata[TO_LSB +: TO_W] = field_q;
    rdata[EN_BIT] = en_q;
  end

  assert_enable_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);
endmodule

// File: rtl/wdk_key_check.sv
module wdk_key_check
  import wdk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_svc,
  input  logic [REG_W-1:0] wdata,
  output logic             reload
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) armed_q <= 1'b0;
    else if (wr_svc) armed_q <= (wdata == KEY_FIRST);
  end

  assign reload = wr_svc && armed_q && (wdata == KEY_SECOND);

  assert_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_svc && wdata != KEY_FIRST) |=> !armed_q);
  assert_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_svc && wdata == KEY_FIRST) |=> armed_q);
endmodule

// File: rtl/wdk_countdown.sv
module wdk_countdown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic [CNT_W-1:0] start_val,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  output logic             fire,
  output logic             expired_q
);
  logic [CNT_W-1:0] cnt_q;

  assign fire = !expired_q && enable && tick && !start && !reload && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else if (!expired_q) begin
      if (start)                cnt_q <= start_val;
      else if (reload)          cnt_q <= reload_val;
      else if (enable && tick) begin
        if (cnt_q == '0) expired_q <= 1'b1;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assert_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> expired_q);
  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expired_q |=> ($stable(cnt_q) && expired_q));
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !start && !reload) |=> $stable(cnt_q));
endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  localparam int PW = $clog2(PULSE_CYC + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              left_q <= '0;
    else if (fire)           left_q <= PW'(PULSE_CYC);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign pulse = (left_q != '0);

  assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pulse);
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdk_pkg::*;
#(
  parameter int PULSE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_tick,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             wdt_rst
);
  logic wr_ctrl, wr_svc, en_q, start, reload, fire, expired_q;
  logic [TO_W-1:0] field_q, start_val;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_svc  = reg_wr && (reg_addr == ADDR_SVC);

  wdk_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(reg_wdata),
    .field_q(field_q), .en_q(en_q), .start(start), .start_val(start_val),
    .rdata(reg_rdata)
  );

  wdk_key_check u_key (
    .clk(clk), .rst_n(rst_n), .wr_svc(wr_svc), .wdata(reg_wdata), .reload(reload)
  );

  wdk_countdown #(.CNT_W(TO_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(en_q), .start(start), .start_val(start_val),
    .reload(reload), .reload_val(field_q), .tick(half_tick),
    .fire(fire), .expired_q(expired_q)
  );

  wdk_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .pulse(wdt_rst)
  );

  assert_no_rst_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wdt_rst) |=> !wdt_rst);
  assert_rst_means_expired_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> expired_q);
endmodule

// File: tb/test_wdog_keyed.sv
module test_wdog_keyed;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_tick = 1'b0;
  logic reg_wr = 1'b0;
  logic reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic wdt_rst;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // behavioural reference state
  int m_field, m_en, m_cnt, m_armed, m_exp, m_pulse;

  always #5 clk = ~clk;

  wdog_keyed i_wdog_keyed (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wdt_rst(wdt_rst)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_field = 127; m_en = 0; m_cnt = 0; m_armed = 0; m_exp = 0; m_pulse = 0;
    end else begin
      int   dfield;
      bit   go, rl, fire;
      dfield = int'(reg_wdata[15:8]);
      go = reg_wr && !reg_addr && reg_wdata[2] && (m_en == 0);
      rl = reg_wr && reg_addr && (m_armed != 0) && (reg_wdata == 16'hAAAA);
      fire = 0;
      if (m_exp == 0) begin
        if (go) m_cnt = dfield;
        else if (rl) m_cnt = m_field;
        else if (m_en != 0 && half_tick) begin
          if (m_cnt == 0) fire = 1; else m_cnt = m_cnt - 1;
        end
      end
      if (fire) begin m_pulse = 4; m_exp = 1; end
      else if (m_pulse > 0) m_pulse = m_pulse - 1;
      if (reg_wr && reg_addr) m_armed = (reg_wdata == 16'h5555) ? 1 : 0;
      if (reg_wr && !reg_addr) begin
        m_field = dfield;
        if (reg_wdata[2]) m_en = 1;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (wdt_rst !== (m_pulse > 0)) begin
        fails++;
        $display("FAIL %s: wdt_rst actual %0b expected %0b", cur_req, wdt_rst, m_pulse > 0);
      end
      checks++;
      if (reg_rdata !== 16'(m_field * 256 + m_en * 4)) begin
        fails++;
        $display("FAIL %s: reg_rdata actual %h expected %h", cur_req, reg_rdata,
                 16'(m_field * 256 + m_en * 4));
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 1'b0; half_tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // one tick; returns with wdt_rst showing the result of that tick
  task automatic tick();
    @(negedge clk);
    half_tick = 1'b1;
    @(negedge clk);
    half_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic service();
    wr(1'b1, 16'h5555);
    wr(1'b1, 16'hAAAA);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int high;
    // R1
    cur_req = "R1";
    do_reset();
    @(negedge clk);
    chk("R1", reg_rdata, 16'h7F00);
    chk("R1", {15'd0, wdt_rst}, 16'd0);

    // R9: no counting while disabled
    cur_req = "R9";
    ticks(20);
    chk("R9", {15'd0, wdt_rst}, 16'd0);

    // R2: layout, unused bits read zero
    cur_req = "R2";
    wr(1'b0, 16'hFFFB);
    chk("R2", reg_rdata, 16'hFF00);
    wr(1'b0, 16'h0304);
    chk("R2", reg_rdata, 16'h0304);

    // R4: k=3 expires on 4th tick
    cur_req = "R4";
    ticks(3);
    chk("R4", {15'd0, wdt_rst}, 16'd0);
    tick();
    chk("R4", {15'd0, wdt_rst}, 16'd1);

    // R8: width 4, then quiet
    cur_req = "R8";
    high = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (wdt_rst) high++;
    end
    chk("R8", 16'(high), 16'd4);
    service();
    ticks(10);
    chk("R8", {15'd0, wdt_rst}, 16'd0);

    // R3: sticky enable
    cur_req = "R3";
    do_reset();
    wr(1'b0, 16'h0A04);
    wr(1'b0, 16'h0B00);
    chk("R3", reg_rdata, 16'h0B04);
    wr(1'b0, 16'hFFFB);
    chk("R3", reg_rdata, 16'hFF04);

    // R5: reload
    cur_req = "R5";
    do_reset();
    wr(1'b0, 16'h0204);
    ticks(2);
    service();
    ticks(2);
    chk("R5", {15'd0, wdt_rst}, 16'd0);
    tick();
    chk("R5", {15'd0, wdt_rst}, 16'd1);

    // R6: cancelled sequence and lone second key
    cur_req = "R6";
    do_reset();
    wr(1'b0, 16'h0204);
    ticks(2);
    wr(1'b1, 16'h5555);
    wr(1'b1, 16'h1234);
    wr(1'b1, 16'hAAAA);
    wr(1'b1, 16'hAAAA);
    tick();
    chk("R6", {15'd0, wdt_rst}, 16'd1);

    // R7: repeated first key keeps armed
    cur_req = "R7";
    do_reset();
    wr(1'b0, 16'h0204);
    ticks(2);
    wr(1'b1, 16'h5555);
    wr(1'b1, 16'h5555);
    wr(1'b1, 16'hAAAA);
    ticks(2);
    chk("R7", {15'd0, wdt_rst}, 16'd0);
    tick();
    chk("R7", {15'd0, wdt_rst}, 16'd1);

    // R10: default field 0x7F -> 128 ticks
    cur_req = "R10";
    do_reset();
    wr(1'b0, 16'h7F04);
    ticks(127);
    chk("R10", {15'd0, wdt_rst}, 16'd0);
    tick();
    chk("R10", {15'd0, wdt_rst}, 16'd1);

    // R11: reload beats a same-cycle tick
    cur_req = "R11";
    do_reset();
    wr(1'b0, 16'h0104);
    tick();
    wr(1'b1, 16'h5555);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 16'hAAAA; half_tick = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; half_tick = 1'b0;
    tick();
    chk("R11", {15'd0, wdt_rst}, 16'd0);
    tick();
    chk("R11", {15'd0, wdt_rst}, 16'd1);

    repeat (6) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule